// File: doc/BRIEF.md
# Inset Window Overlay Generator

This block decides, pixel by pixel, whether the output raster shows the main picture or a reduced inset picture. It also produces the colour used for the inset's border and background fill. It counts pixels from the rising edge of the main horizontal sync and lines from the rising edge of the main vertical sync. It then compares the two counts with a programmable window origin and one of two fixed inset sizes.

Inside the window the block drives a window-active flag and the read address of the current inset pixel and line. The video memory uses that address to fetch the stored sub-picture. A border ring can be drawn just outside the image area. A mute option replaces the inset content with a flat background colour. The main/sub switch output can be delayed by a programmable number of pixel clocks to line it up with the video path. On 50 Hz main video, the vertical origin can optionally be stretched by a factor of 1.2.

Top module: `pip_window_gen`

## Requirements
- R1: While reset is asserted, every output is 0: sw_sub, win_active, border, rd_x, rd_y, ov_sel and the colour fields.
- R2: Pixel and line counters:
  - The pixel count x restarts at 0 on the clock edge where a rising hd is seen. On every other edge it increments and saturates at its all-ones value.
  - The line count y increments on each hd rising edge and saturates at all-ones.
  - A vd rising edge sets y to 0 and takes priority over the increment.
- R3: Image region and read address:
  - The effective horizontal origin is hs = hpos + disp_adj.
  - One clock after the counters hold (x, y), win_active is 1 exactly when disp_en = 1, hs <= x < hs + W and vs <= y < vs + H.
  - In that case rd_x = x - hs and rd_y = y - vs. Otherwise both are 0.
- R4: Inset size: size_h = 0 selects width W = W_LARGE (229 by default) and size_h = 1 selects W_SMALL (172). size_v = 0 selects height H = H_LARGE (69) and size_v = 1 selects H_SMALL (52).
- R5: With disp_en = 0, win_active, border, ov_sel and sw_sub all remain 0.
- R6: Border ring:
  - With frame_en = 1 and disp_en = 1, border is 1 for pixels outside the image that satisfy hs <= x + 2 < hs + W + 4 and vs <= y + 1 < vs + H + 2.
  - The ring is therefore two pixels wide at the sides and one line high at the top and bottom.
- R7: Border colour: on border pixels ov_sel = 1. The colour is {edge_y, edge_u, edge_v} when edge_indep = 1, and {bg_y, bg_u, bg_v} otherwise.
- R8: Mute: in the image region with mute = 1, ov_sel = 1 and the colour is {bg_y, bg_u, bg_v}. With mute = 0, ov_sel = 0 in the image region.
- R9: Vertical origin:
  - When vscale_en = 1 and field50 = 1, vs = floor(vpos * 6 / 5).
  - Otherwise vs = vpos.
  - vs is taken through a register.
- R10: sw_sub equals (win_active | border) delayed by sw_delay clock cycles, where 0 means no extra delay.
- R11: Whenever ov_sel = 0, ov_y, ov_u and ov_v are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd | input | 1 | Main horizontal sync, rising edge starts a line |
| vd | input | 1 | Main vertical sync, rising edge starts a field |
| disp_en | input | 1 | Inset display enable |
| size_h | input | 1 | Horizontal size select (0 large, 1 small) |
| size_v | input | 1 | Vertical size select (0 large, 1 small) |
| frame_en | input | 1 | Border ring enable |
| edge_indep | input | 1 | Border uses its own colour |
| mute | input | 1 | Replace inset content with background colour |
| vpos | input | POS_W | Vertical window origin |
| hpos | input | POS_W | Horizontal window origin |
| vscale_en | input | 1 | Enable 1.2x vertical origin on 50 Hz |
| field50 | input | 1 | Main video is 50 Hz |
| sw_delay | input | DLY_W | Switch output delay in clocks |
| disp_adj | input | 4 | Horizontal display timing trim |
| bg_y | input | 4 | Background Y level |
| bg_u | input | 3 | Background U level |
| bg_v | input | 3 | Background V level |
| edge_y | input | 4 | Border Y level |
| edge_u | input | 3 | Border U level |
| edge_v | input | 3 | Border V level |
| sw_sub | output | 1 | Main/sub switch, 1 selects the inset |
| win_active | output | 1 | Current pixel is inside the inset image |
| border | output | 1 | Current pixel is on the border ring |
| rd_x | output | HCNT_W | Inset read pixel address |
| rd_y | output | VCNT_W | Inset read line address |
| ov_sel | output | 1 | Overlay colour valid |
| ov_y | output | 4 | Overlay Y |
| ov_u | output | 3 | Overlay U |
| ov_v | output | 3 | Overlay V |

## Verification
The bench shrinks the inset sizes and counter widths so that whole fields can be swept pixel by pixel. It predicts every output from an arithmetic model of the counters and of the window bounds.

The configurations each separate specific behaviours:
- Both size selections, to tell the large inset from the small one.
- Scaled and unscaled vertical origins, including a case where truncation of the 1.2 factor matters.
- An origin at zero, where the border ring is clipped.
- Display off, with every other option enabled.
- Mute with shared and with independent border colour, to tell which colour source is used.
- Several switch delays.

One configuration uses long lines and many lines so that both counters saturate while still inside the window.

// File: rtl/pip_pkg.sv
package pip_pkg;
    localparam int Y_W = 4;
    localparam int C_W = 3;

    typedef struct packed {
        logic [Y_W-1:0] y;
        logic [C_W-1:0] u;
        logic [C_W-1:0] v;
    } pip_col_t;
endpackage

// File: rtl/pip_sync_counter.sv
module pip_sync_counter #(
    parameter int HCNT_W = 11,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd,
    input  logic              vd,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt
);
    localparam logic [HCNT_W-1:0] HMAX = '1;
    localparam logic [VCNT_W-1:0] VMAX = '1;

    typedef struct packed {
        logic              hd;
        logic              vd;
        logic [HCNT_W-1:0] h;
        logic [VCNT_W-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        logic h_rise, v_rise;
        cnt_d    = cnt_q;
        h_rise   = hd & ~cnt_q.hd;
        v_rise   = vd & ~cnt_q.vd;
        cnt_d.hd = hd;
        cnt_d.vd = vd;
        if (h_rise)
            cnt_d.h = '0;
        else if (cnt_q.h != HMAX)
            cnt_d.h = cnt_q.h + 1'b1;
        if (v_rise)
            cnt_d.v = '0;
        else if (h_rise && cnt_q.v != VMAX)
            cnt_d.v = cnt_q.v + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hcnt = cnt_q.h;
    assign vcnt = cnt_q.v;
endmodule

// File: rtl/pip_vstart_scale.sv
module pip_vstart_scale #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] vpos,
    input  logic             scale_en,
    input  logic             field50,
    output logic [POS_W:0]   vstart
);
    localparam int PW  = POS_W + 3;
    localparam int VSW = POS_W + 1;

    typedef struct packed {
        logic [VSW-1:0] vs;
    } vs_t;

    vs_t vs_d, vs_q;

    always_comb begin
        logic [PW-1:0] prod;
        prod = PW'(vpos) * PW'(6);
        if (scale_en && field50)
            vs_d.vs = VSW'(prod / PW'(5));
        else
            vs_d.vs = VSW'(vpos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    assign vstart = vs_q.vs;
endmodule

// File: rtl/pip_region_cmp.sv
module pip_region_cmp
    import pip_pkg::*;
#(
    parameter int HCNT_W  = 11,
    parameter int VCNT_W  = 10,
    parameter int POS_W   = 8,
    parameter int W_LARGE = 229,
    parameter int W_SMALL = 172,
    parameter int H_LARGE = 69,
    parameter int H_SMALL = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] x,
    input  logic [VCNT_W-1:0] y,
    input  logic [POS_W:0]    hstart,
    input  logic [POS_W:0]    vstart,
    input  logic              size_h,
    input  logic              size_v,
    input  logic              disp_en,
    input  logic              frame_en,
    input  logic              edge_indep,
    input  logic              mute,
    input  pip_col_t          bg_col,
    input  pip_col_t          edge_col,
    output logic              act,
    output logic              bdr,
    output logic              sw,
    output logic [HCNT_W-1:0] rx,
    output logic [VCNT_W-1:0] ry,
    output logic              sel,
    output pip_col_t          col
);
    localparam int CW = HCNT_W + VCNT_W + POS_W;
    localparam logic [CW-1:0] WL = CW'(W_LARGE);
    localparam logic [CW-1:0] WS = CW'(W_SMALL);
    localparam logic [CW-1:0] HL = CW'(H_LARGE);
    localparam logic [CW-1:0] HS = CW'(H_SMALL);

    typedef struct packed {
        logic              act;
        logic              bdr;
        logic              sw;
        logic [HCNT_W-1:0] rx;
        logic [VCNT_W-1:0] ry;
        logic              sel;
        pip_col_t          col;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        logic [CW-1:0] xe, ye, hs, vs, wd, ht;
        logic in_x, in_y, ring_x, ring_y, img, ring;
        xe = CW'(x);
        ye = CW'(y);
        hs = CW'(hstart);
        vs = CW'(vstart);
        wd = size_h ? WS : WL;
        ht = size_v ? HS : HL;
        in_x   = (xe >= hs) && (xe < hs + wd);
        in_y   = (ye >= vs) && (ye < vs + ht);
        ring_x = (xe + CW'(2) >= hs) && (xe < hs + wd + CW'(2));
        ring_y = (ye + CW'(1) >= vs) && (ye < vs + ht + CW'(1));
        img    = in_x && in_y;
        ring   = ring_x && ring_y;

        r_d     = '0;
        r_d.act = disp_en && img;
        r_d.bdr = disp_en && frame_en && ring && !img;
        r_d.sw  = r_d.act || r_d.bdr;
        if (r_d.act) begin
            r_d.rx = x - HCNT_W'(hstart);
            r_d.ry = y - VCNT_W'(vstart);
        end
        if (r_d.bdr) begin
            r_d.sel = 1'b1;
            r_d.col = edge_indep ? edge_col : bg_col;
        end else if (r_d.act && mute) begin
            r_d.sel = 1'b1;
            r_d.col = bg_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign act = r_q.act;
    assign bdr = r_q.bdr;
    assign sw  = r_q.sw;
    assign rx  = r_q.rx;
    assign ry  = r_q.ry;
    assign sel = r_q.sel;
    assign col = r_q.col;
endmodule

// File: rtl/pip_switch_delay.sv
module pip_switch_delay #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_in,
    input  logic [DLY_W-1:0] sel,
    output logic             sw_out
);
    localparam int DEPTH = 1 << DLY_W;

    typedef struct packed {
        logic [DEPTH-1:1] pipe;
    } dl_t;

    dl_t dl_d, dl_q;
    logic [DEPTH-1:0] taps;

    assign taps[0] = sw_in;
    for (genvar k = 1; k < DEPTH; k++) begin : g_tap
        assign taps[k] = dl_q.pipe[k];
    end

    always_comb begin
        dl_d = dl_q;
        dl_d.pipe[1] = sw_in;
        for (int k = 2; k < DEPTH; k++)
            dl_d.pipe[k] = dl_q.pipe[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    assign sw_out = taps[sel];
endmodule

// File: rtl/pip_window_gen.sv
module pip_window_gen
    import pip_pkg::*;
#(
    parameter int HCNT_W  = 11,
    parameter int VCNT_W  = 10,
    parameter int POS_W   = 8,
    parameter int DLY_W   = 4,
    parameter int W_LARGE = 229,
    parameter int W_SMALL = 172,
    parameter int H_LARGE = 69,
    parameter int H_SMALL = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd,
    input  logic              vd,
    input  logic              disp_en,
    input  logic              size_h,
    input  logic              size_v,
    input  logic              frame_en,
    input  logic              edge_indep,
    input  logic              mute,
    input  logic [POS_W-1:0]  vpos,
    input  logic [POS_W-1:0]  hpos,
    input  logic              vscale_en,
    input  logic              field50,
    input  logic [DLY_W-1:0]  sw_delay,
    input  logic [3:0]        disp_adj,
    input  logic [3:0]        bg_y,
    input  logic [2:0]        bg_u,
    input  logic [2:0]        bg_v,
    input  logic [3:0]        edge_y,
    input  logic [2:0]        edge_u,
    input  logic [2:0]        edge_v,
    output logic              sw_sub,
    output logic              win_active,
    output logic              border,
    output logic [HCNT_W-1:0] rd_x,
    output logic [VCNT_W-1:0] rd_y,
    output logic              ov_sel,
    output logic [3:0]        ov_y,
    output logic [2:0]        ov_u,
    output logic [2:0]        ov_v
);
    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic [POS_W:0]    vstart;
    logic [POS_W:0]    hstart;
    logic              sw_reg;
    pip_col_t          bg_col, edge_col, ov_col;

    assign hstart   = (POS_W+1)'(hpos) + (POS_W+1)'(disp_adj);
    assign bg_col   = '{y: bg_y, u: bg_u, v: bg_v};
    assign edge_col = '{y: edge_y, u: edge_u, v: edge_v};

    pip_sync_counter #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .hcnt(hcnt), .vcnt(vcnt)
    );

    pip_vstart_scale #(.POS_W(POS_W)) vsc_i (
        .clk(clk), .rst_n(rst_n), .vpos(vpos), .scale_en(vscale_en),
        .field50(field50), .vstart(vstart)
    );

    pip_region_cmp #(
        .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .POS_W(POS_W),
        .W_LARGE(W_LARGE), .W_SMALL(W_SMALL), .H_LARGE(H_LARGE), .H_SMALL(H_SMALL)
    ) reg_i (
        .clk(clk), .rst_n(rst_n), .x(hcnt), .y(vcnt),
        .hstart(hstart), .vstart(vstart),
        .size_h(size_h), .size_v(size_v), .disp_en(disp_en),
        .frame_en(frame_en), .edge_indep(edge_indep), .mute(mute),
        .bg_col(bg_col), .edge_col(edge_col),
        .act(win_active), .bdr(border), .sw(sw_reg),
        .rx(rd_x), .ry(rd_y), .sel(ov_sel), .col(ov_col)
    );

    pip_switch_delay #(.DLY_W(DLY_W)) dly_i (
        .clk(clk), .rst_n(rst_n), .sw_in(sw_reg), .sel(sw_delay), .sw_out(sw_sub)
    );

    assign ov_y = ov_col.y;
    assign ov_u = ov_col.u;
    assign ov_v = ov_col.v;
endmodule

// File: rtl/pip_window_chk.sv
module pip_window_chk #(
    parameter int HCNT_W = 11,
    parameter int VCNT_W = 10,
    parameter int DLY_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              disp_en,
    input logic              frame_en,
    input logic              mute,
    input logic [DLY_W-1:0]  sw_delay,
    input logic              sw_sub,
    input logic              win_active,
    input logic              border,
    input logic [HCNT_W-1:0] rd_x,
    input logic [VCNT_W-1:0] rd_y,
    input logic              ov_sel,
    input logic [3:0]        ov_y,
    input logic [2:0]        ov_u,
    input logic [2:0]        ov_v
);
    assert_disp_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(disp_en) |-> (!win_active && !border && !ov_sel));

    assert_ring_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_active && border));

    assert_ring_needs_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        border |-> $past(frame_en));

    assert_addr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |-> (rd_x == '0 && rd_y == '0));

    assert_colour_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ov_sel |-> (ov_y == '0 && ov_u == '0 && ov_v == '0));

    assert_mute_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && $past(mute)) |-> ov_sel);

    assert_zero_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_delay == '0) |-> (sw_sub == (win_active || border)));
endmodule

bind pip_window_gen pip_window_chk #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .DLY_W(DLY_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .frame_en(frame_en), .mute(mute),
    .sw_delay(sw_delay), .sw_sub(sw_sub), .win_active(win_active), .border(border),
    .rd_x(rd_x), .rd_y(rd_y), .ov_sel(ov_sel), .ov_y(ov_y), .ov_u(ov_u), .ov_v(ov_v)
);

// File: tb/pip_window_gen_tb.sv
module pip_window_gen_tb_top;
    localparam int HW = 6, VW = 5, PW = 8, DW = 4;
    localparam int WL = 6, WS = 4, HL = 5, HS = 3;
    localparam int HMAX = (1 << HW) - 1, VMAX = (1 << VW) - 1;

    logic clk = 0, rst_n = 0, hd = 0, vd = 0;
    logic disp_en = 0, size_h = 0, size_v = 0, frame_en = 0, edge_indep = 0, mute = 0;
    logic [PW-1:0] vpos = 0, hpos = 0;
    logic vscale_en = 0, field50 = 0;
    logic [DW-1:0] sw_delay = 0;
    logic [3:0] disp_adj = 0;
    logic [3:0] bg_y = 4'hA, edge_y = 4'hC;
    logic [2:0] bg_u = 3'h3, bg_v = 3'h5, edge_u = 3'h6, edge_v = 3'h1;
    logic sw_sub, win_active, border, ov_sel;
    logic [HW-1:0] rd_x;
    logic [VW-1:0] rd_y;
    logic [3:0] ov_y;
    logic [2:0] ov_u, ov_v;

    always #2 clk = ~clk;

    pip_window_gen #(.HCNT_W(HW), .VCNT_W(VW), .POS_W(PW), .DLY_W(DW),
        .W_LARGE(WL), .W_SMALL(WS), .H_LARGE(HL), .H_SMALL(HS)) dut_i (
        .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .disp_en(disp_en),
        .size_h(size_h), .size_v(size_v), .frame_en(frame_en), .edge_indep(edge_indep),
        .mute(mute), .vpos(vpos), .hpos(hpos), .vscale_en(vscale_en), .field50(field50),
        .sw_delay(sw_delay), .disp_adj(disp_adj), .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
        .edge_y(edge_y), .edge_u(edge_u), .edge_v(edge_v), .sw_sub(sw_sub),
        .win_active(win_active), .border(border), .rd_x(rd_x), .rd_y(rd_y),
        .ov_sel(ov_sel), .ov_y(ov_y), .ov_u(ov_u), .ov_v(ov_v));

    int n_chk = 0, n_fail = 0;
    int mx = 0, my = 0, settle = 0;
    bit hd_prev = 0, vd_prev = 0, pend_valid = 0;
    bit hist [16];
    bit e_act, e_bdr, e_sel, e_sw;
    int e_rx, e_ry, e_col;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", tag, act, exp, mx, my);
        end
    endtask

    task automatic step(input bit h, input bit v);
        int vs, hs, w, ht, c;
        bit img, ring;
        @(negedge clk);
        if (pend_valid && settle == 0) begin
            chk(win_active == e_act, "R3 R4 R9 win_active", int'(win_active), int'(e_act));
            chk(rd_x == e_rx && rd_y == e_ry, "R2 R3 rd address", int'(rd_x) * 100 + int'(rd_y), e_rx * 100 + e_ry);
            chk(border == e_bdr, "R5 R6 border", int'(border), int'(e_bdr));
            c = {ov_y, ov_u, ov_v};
            chk(ov_sel == e_sel && c == e_col, "R7 R8 R11 colour", int'(ov_sel) * 1024 + c, int'(e_sel) * 1024 + e_col);
            chk(sw_sub == e_sw, "R10 R5 switch", int'(sw_sub), int'(e_sw));
        end
        if (settle > 0) settle--;
        vs = (vscale_en && field50) ? (int'(vpos) * 6) / 5 : int'(vpos);
        hs = int'(hpos) + int'(disp_adj);
        w  = size_h ? WS : WL;
        ht = size_v ? HS : HL;
        img  = mx >= hs && mx < hs + w && my >= vs && my < vs + ht;
        ring = mx + 2 >= hs && mx < hs + w + 2 && my + 1 >= vs && my < vs + ht + 1;
        e_act = disp_en && img;
        e_bdr = disp_en && frame_en && ring && !img;
        e_rx  = e_act ? mx - hs : 0;
        e_ry  = e_act ? my - vs : 0;
        e_sel = e_bdr || (e_act && mute);
        if (e_bdr)
            e_col = edge_indep ? int'({edge_y, edge_u, edge_v}) : int'({bg_y, bg_u, bg_v});
        else if (e_act && mute)
            e_col = int'({bg_y, bg_u, bg_v});
        else
            e_col = 0;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = e_act || e_bdr;
        e_sw = hist[sw_delay];
        pend_valid = 1;
        hd = h;
        vd = v;
        if (h && !hd_prev) mx = 0;
        else if (mx < HMAX) mx++;
        if (v && !vd_prev) my = 0;
        else if (h && !hd_prev && my < VMAX) my++;
        hd_prev = h;
        vd_prev = v;
    endtask

    task automatic run_frame(input int lines, input int len);
        for (int l = 0; l < lines; l++)
            for (int c = 0; c < len; c++)
                step(c == 0, c == 0 && l == 0);
    endtask

    task automatic cfg(input int vp, input int hp, input int da, input bit sh, input bit sv,
                       input bit de, input bit fe, input bit ei, input bit mu,
                       input bit vse, input bit f50, input int sd);
        vpos = PW'(vp); hpos = PW'(hp); disp_adj = 4'(da);
        size_h = sh; size_v = sv; disp_en = de; frame_en = fe; edge_indep = ei;
        mute = mu; vscale_en = vse; field50 = f50; sw_delay = DW'(sd);
        settle = 20;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs while in reset
        chk(!sw_sub && !win_active && !border && !ov_sel && rd_x == 0 && rd_y == 0
            && ov_y == 0 && ov_u == 0 && ov_v == 0, "R1 reset state", int'(win_active), 0);
        rst_n = 1;
        cfg(4, 8, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);  run_frame(24, 40);
        cfg(4, 8, 3, 1, 1, 1, 1, 1, 0, 0, 0, 2);  run_frame(24, 40);  // R4 small sizes
        cfg(10, 5, 1, 0, 1, 1, 1, 0, 1, 1, 1, 5); run_frame(24, 40);  // R9 vs=12
        cfg(9, 2, 0, 1, 0, 1, 1, 1, 1, 1, 1, 15); run_frame(24, 40);  // R9 vs=10 truncated
        cfg(9, 2, 0, 0, 0, 0, 1, 1, 1, 1, 1, 3);  run_frame(24, 40);  // R5 display off
        cfg(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);  run_frame(24, 40);  // R6 clipped ring
        cfg(9, 4, 2, 0, 0, 1, 0, 1, 1, 1, 0, 7);  run_frame(24, 40);  // R9 no 50 Hz
        cfg(28, 60, 0, 0, 0, 1, 1, 0, 1, 0, 0, 1); run_frame(35, 70); // R2 saturation
        finish_run();
    end
endmodule